// File: doc/BRIEF.md
# Dual-Channel 8-bit Timer Waveform Generator

This block turns an 8-bit timer count into two waveform bits. One counter is shared by both channels and runs in one of four ways. It can free-run, clear on a compare value, count over a single slope for fast PWM, or count up and down over a dual slope for phase-correct PWM. The counter advances only when the timer-clock enable `tick` is high. The prescaler that produces `tick` lives outside this block, and so does the pin direction logic that uses the wave bits.

Each channel holds a live 8-bit compare value and a 2-bit action code. On a compare match, and at the counter's turning points, the code decides whether the channel's output bit holds, toggles, goes low or goes high. In the PWM modes the period can be either 255 counts or the value of channel A's compare input. In that case channel A sets the period and can only toggle. The block also gives an overflow pulse, the live count and a count-down indicator.

There is no data stream here. All pins are plain control and status signals, with no handshake.

Top module: `pwm_wavegen`

## Requirements
- R1: After reset, the count is 0, both wave bits are 0, `cnt_down` is 0 and `ovf` is 0.
- R2: With `wg_kind`=0 (free-run), each tick adds one to the count, and 255 wraps to 0. `ovf` is high for the one cycle that follows the tick that moves the count from 255 to 0.
- R3: With `wg_kind`=1 (clear on compare), the tick taken while the count is greater than or equal to `cmp_a` loads 0. `ovf` pulses only on a 255-to-0 step.
- R4: In modes 0 and 1, a tick whose count equals a channel's compare value applies that channel's action code: 1 toggles the bit, 2 drives it low, 3 drives it high and 0 leaves it unchanged.
- R5: In modes 0 and 1, a high `force_a`/`force_b` applies the match action of that channel at the next clock edge, with or without a tick. If a strobe and a tick match fall in the same cycle, the action is applied once. In modes 2 and 3 the strobes have no effect.
- R6: With `wg_kind`=2 (fast PWM), the count climbs from 0 to TOP and loads 0 on the tick after it reaches TOP. `ovf` pulses in the cycle after the count arrives at TOP.
- R7: In fast PWM, code 2 drives the bit low on a match and high on the tick that wraps from TOP. Code 3 does the opposite. When both happen on the same tick, the wrap action wins.
- R8: With `wg_kind`=3 (phase-correct), the count climbs to TOP and then descends to 0. `cnt_down` becomes 1 as the count arrives at TOP and 0 as it arrives at 0. `ovf` pulses as the count arrives at 0. In every other mode, `cnt_down` is 0 from the next cycle on.
- R9: In phase-correct mode, code 2 drives the bit low on a match while `cnt_down`=0 and high on a match while `cnt_down`=1. Code 3 does the opposite. As a result, a compare value of 0 gives a bit that stays low, and a compare value equal to TOP gives a bit that stays high.
- R10: In modes 2 and 3, `top_sel`=1 makes TOP equal to `cmp_a`, and `top_sel`=0 makes TOP equal to 255. With `top_sel`=1, channel A toggles on a match under code 1 and holds under every other code. Code 1 holds channel B in both PWM modes, and it holds channel A when `top_sel`=0.
- R11: A new action code changes no output when it is written. It acts first at the next match or wrap event.
- R12: While `tick` is low and no strobe is applied, the count, both wave bits and `ovf`=0 stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable |
| wg_kind | input | 2 | Mode: 0 free-run, 1 clear on compare, 2 fast PWM, 3 phase-correct |
| top_sel | input | 1 | PWM modes only: 1 takes TOP from cmp_a, 0 fixes TOP at 255 |
| cmp_a | input | 8 | Channel A compare value |
| cmp_b | input | 8 | Channel B compare value |
| code_a | input | 2 | Channel A action code |
| code_b | input | 2 | Channel B action code |
| force_a | input | 1 | Channel A forced-match strobe |
| force_b | input | 1 | Channel B forced-match strobe |
| count | output | 8 | Counter value |
| cnt_down | output | 1 | High while the phase-correct counter descends |
| ovf | output | 1 | One-cycle overflow pulse |
| wave_a | output | 1 | Channel A output bit |
| wave_b | output | 1 | Channel B output bit |

## Verification
The hardest cases are the ones where a compare match falls on the same tick as a counter turning point. These are a fast-PWM compare value equal to TOP or equal to 0, and a phase-correct compare value equal to TOP or equal to 0. They also include a forced strobe that lands on a tick that is already matching. The bench provokes each case by setting the compare value onto the turning point, or by repeating a strobe so that it eventually lands on a match. An independent per-cycle model queues the expected count, direction, overflow and wave bits for every clock. The outputs are then judged against those entries, which covers wrap-over-match precedence, the constant-level results and the rule that a coinciding strobe toggles only once.

// File: rtl/pwm_wavegen_pkg.sv
package pwm_wavegen_pkg;
  typedef enum logic [1:0] {
    WG_NORMAL = 2'd0,
    WG_CLEAR  = 2'd1,
    WG_FAST   = 2'd2,
    WG_PHASE  = 2'd3
  } wg_kind_e;

  localparam logic [1:0] ACT_NONE   = 2'd0;
  localparam logic [1:0] ACT_TOGGLE = 2'd1;
  localparam logic [1:0] ACT_LOW    = 2'd2;
  localparam logic [1:0] ACT_HIGH   = 2'd3;

  function automatic logic is_pwm(wg_kind_e k);
    return (k == WG_FAST) || (k == WG_PHASE);
  endfunction
endpackage

// File: rtl/pwm_wg_counter.sv
module pwm_wg_counter
  import pwm_wavegen_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  wg_kind_e      kind,
  input  logic          top_sel,
  input  logic [CW-1:0] cmp_a,
  output logic [CW-1:0] count,
  output logic          cnt_down,
  output logic          ovf,
  output logic          at_top
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] top, nxt;
  logic [CW:0]   inc;
  logic          dn_n, ovf_n;

  always_comb begin
    case (kind)
      WG_NORMAL: top = CMAX;
      WG_CLEAR:  top = cmp_a;
      default:   top = top_sel ? cmp_a : CMAX;
    endcase
    inc    = {1'b0, count} + 1'b1;
    at_top = (count >= top);
    nxt    = at_top ? '0 : inc[CW-1:0];
    dn_n   = 1'b0;
    ovf_n  = 1'b0;
    case (kind)
      WG_NORMAL, WG_CLEAR: ovf_n = (count == CMAX);
      WG_FAST:             ovf_n = (inc == {1'b0, top});
      default: begin
        if (!cnt_down) begin
          if (inc >= {1'b0, top}) begin
            nxt  = top;
            dn_n = 1'b1;
          end else begin
            nxt  = inc[CW-1:0];
          end
        end else if (count <= ONE) begin
          nxt   = '0;
          ovf_n = 1'b1;
        end else begin
          nxt  = count - ONE;
          dn_n = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      cnt_down <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      ovf <= tick & ovf_n;
      if (tick) count <= nxt;
      if (kind != WG_PHASE) cnt_down <= 1'b0;
      else if (tick)        cnt_down <= dn_n;
    end
  end
endmodule

// File: rtl/pwm_wg_channel.sv
module pwm_wg_channel
  import pwm_wavegen_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  wg_kind_e      kind,
  input  logic          toggle_top,
  input  logic          force_cmp,
  input  logic [1:0]    code,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] count,
  input  logic          cnt_down,
  input  logic          at_top,
  output logic          wave
);
  logic hit, inv, nxt;

  always_comb begin
    hit = (count == cmp);
    inv = code[0];
    nxt = wave;
    if (!is_pwm(kind)) begin
      if ((tick && hit) || force_cmp) begin
        case (code)
          ACT_TOGGLE: nxt = ~wave;
          ACT_LOW:    nxt = 1'b0;
          ACT_HIGH:   nxt = 1'b1;
          default:    nxt = wave;
        endcase
      end
    end else if (tick) begin
      if (toggle_top) begin
        if (code == ACT_TOGGLE && hit) nxt = ~wave;
      end else if (code[1]) begin
        if (kind == WG_FAST) begin
          if (at_top)   nxt = ~inv;
          else if (hit) nxt = inv;
        end else if (hit) begin
          nxt = cnt_down ? ~inv : inv;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= nxt;
  end
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_wavegen_pkg::*;
#(
  parameter int CW    = 8,
  parameter int NCHAN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    wg_kind,
  input  logic          top_sel,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [1:0]    code_a,
  input  logic [1:0]    code_b,
  input  logic          force_a,
  input  logic          force_b,
  output logic [CW-1:0] count,
  output logic          cnt_down,
  output logic          ovf,
  output logic          wave_a,
  output logic          wave_b
);
  wg_kind_e kind;
  logic     at_top;
  assign kind = wg_kind_e'(wg_kind);

  logic [CW-1:0] cmp_v  [NCHAN];
  logic [1:0]    code_v [NCHAN];
  logic          frc_v  [NCHAN];
  logic          tgl_v  [NCHAN];
  logic          wave_v [NCHAN];

  assign cmp_v[0]  = cmp_a;
  assign cmp_v[1]  = cmp_b;
  assign code_v[0] = code_a;
  assign code_v[1] = code_b;
  assign frc_v[0]  = force_a;
  assign frc_v[1]  = force_b;
  assign wave_a    = wave_v[0];
  assign wave_b    = wave_v[1];

  pwm_wg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kind(kind), .top_sel(top_sel),
    .cmp_a(cmp_a), .count(count), .cnt_down(cnt_down), .ovf(ovf), .at_top(at_top)
  );

  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    if (i == 0) begin : g_period_owner
      assign tgl_v[i] = is_pwm(kind) & top_sel;
    end else begin : g_plain
      assign tgl_v[i] = 1'b0;
    end
    pwm_wg_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .kind(kind), .toggle_top(tgl_v[i]),
      .force_cmp(frc_v[i]), .code(code_v[i]), .cmp(cmp_v[i]), .count(count),
      .cnt_down(cnt_down), .at_top(at_top), .wave(wave_v[i])
    );
  end
endmodule

// File: rtl/pwm_wavegen_chk.sv
module pwm_wavegen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [1:0]    wg_kind,
  input logic          top_sel,
  input logic [CW-1:0] cmp_a,
  input logic          force_a,
  input logic          force_b,
  input logic [CW-1:0] count,
  input logic          cnt_down,
  input logic          ovf,
  input logic          wave_a,
  input logic          wave_b
);
  localparam logic [CW-1:0] CMAX = '1;

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_a && !force_b) |=> ($stable(count) && $stable(wave_a) && $stable(wave_b) && !ovf));

  a_r5_strobe_ignored_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_kind[1] && !tick) |=> ($stable(wave_a) && $stable(wave_b)));

  a_r8_down_only_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_kind != 2'd3) |=> !cnt_down);

  a_r2_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_kind == 2'd0 && tick && count == CMAX) |=> (count == '0 && ovf));

  a_r3_clear_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_kind == 2'd1 && tick && count >= cmp_a) |=> (count == '0));

  a_r8_bottom_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_kind == 2'd3 && tick && cnt_down && count == {{(CW-1){1'b0}}, 1'b1})
    |=> (count == '0 && !cnt_down && ovf));

  a_r6_fast_ovf_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && $past(wg_kind) == 2'd2) |-> (count == ($past(top_sel) ? $past(cmp_a) : CMAX)));
endmodule

bind pwm_wavegen pwm_wavegen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wg_kind(wg_kind), .top_sel(top_sel),
  .cmp_a(cmp_a), .force_a(force_a), .force_b(force_b), .count(count),
  .cnt_down(cnt_down), .ovf(ovf), .wave_a(wave_a), .wave_b(wave_b)
);

// File: tb/sim_pwm_wavegen.sv
`timescale 1ns/1ps
module sim_pwm_wavegen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] wg_kind = 2'd0;
  logic       top_sel = 1'b0;
  logic [7:0] cmp_a = 8'd0, cmp_b = 8'd0;
  logic [1:0] code_a = 2'd0, code_b = 2'd0;
  logic       force_a = 1'b0, force_b = 1'b0;
  logic [7:0] count;
  logic       cnt_down, ovf, wave_a, wave_b;

  always #5 clk = ~clk;

  pwm_wavegen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wg_kind(wg_kind), .top_sel(top_sel),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .code_a(code_a), .code_b(code_b),
    .force_a(force_a), .force_b(force_b), .count(count), .cnt_down(cnt_down),
    .ovf(ovf), .wave_a(wave_a), .wave_b(wave_b)
  );

  typedef struct {
    logic [7:0] cnt;
    logic dn, ov, a, b;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;

  // scenario configuration, copied onto the pins by the driver
  logic [1:0] c_kind = 0;
  logic c_top = 0;
  logic [7:0] c_cmpa = 0, c_cmpb = 0;
  logic [1:0] c_codea = 0, c_codeb = 0;
  int tick_pat = 0;
  bit frc_en = 0;

  // reference state
  logic [7:0] m_cnt = 0;
  logic m_dn = 0, m_a = 0, m_b = 0;

  function automatic logic chan_next(logic w, bit own_top, logic [1:0] code,
                                     logic [7:0] cmp, logic frc, logic wrapping);
    logic hit;
    hit = (m_cnt == cmp);
    if (c_kind < 2) begin
      if ((tick && hit) || frc)
        return (code == 1) ? ~w : (code == 2) ? 1'b0 : (code == 3) ? 1'b1 : w;
      return w;
    end
    if (!tick) return w;
    if (own_top) return (code == 1 && hit) ? ~w : w;
    if (code < 2) return w;
    if (c_kind == 2) begin
      if (wrapping) return (code == 2);
      if (hit) return (code == 3);
      return w;
    end
    if (hit) return m_dn ? (code == 2) : (code == 3);
    return w;
  endfunction

  task automatic model_step(string tag);
    int top, nc;
    logic ndn, nov, wr, na, nb;
    exp_t e;
    top = (c_kind == 0) ? 255 : (c_kind == 1) ? int'(c_cmpa) : (c_top ? int'(c_cmpa) : 255);
    wr  = (int'(m_cnt) >= top);
    na  = chan_next(m_a, (c_kind >= 2) && c_top, c_codea, c_cmpa, force_a, wr);
    nb  = chan_next(m_b, 1'b0, c_codeb, c_cmpb, force_b, wr);
    ndn = 0; nov = 0;
    nc  = wr ? 0 : int'(m_cnt) + 1;
    if (c_kind < 2) nov = (m_cnt == 8'd255);
    else if (c_kind == 2) nov = (int'(m_cnt) + 1 == top);
    else if (!m_dn) begin
      if (int'(m_cnt) + 1 >= top) begin nc = top; ndn = 1; end
      else nc = int'(m_cnt) + 1;
    end else if (m_cnt <= 1) begin nc = 0; nov = 1; end
    else begin nc = int'(m_cnt) - 1; ndn = 1; end
    if (tick) m_cnt = nc[7:0];
    m_dn = (c_kind != 3) ? 1'b0 : (tick ? ndn : m_dn);
    m_a = na; m_b = nb;
    e.cnt = m_cnt; e.dn = m_dn; e.ov = tick & nov; e.a = m_a; e.b = m_b; e.tag = tag;
    sb.push_back(e);
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      wg_kind = c_kind; top_sel = c_top; cmp_a = c_cmpa; cmp_b = c_cmpb;
      code_a = c_codea; code_b = c_codeb;
      tick = (tick_pat == 0) ? 1'b1 : (tick_pat == 1) ? (i % 3 != 0) : 1'b0;
      force_a = frc_en && (i % 7 == 3);
      force_b = frc_en && (i % 11 == 5);
      model_step(tag);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0; tick = 0; force_a = 0; force_b = 0;
    m_cnt = 0; m_dn = 0; m_a = 0; m_b = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    #1;
    checks++;
    if (count !== 8'd0 || wave_a !== 1'b0 || wave_b !== 1'b0 || cnt_down !== 1'b0 || ovf !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: cnt=%0d a=%b b=%b dn=%b ovf=%b expected 0 0 0 0 0",
               count, wave_a, wave_b, cnt_down, ovf);
    end
  endtask

  // monitor: compares each queued expectation one step after its edge
  initial forever begin
    @(posedge clk); #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (count !== e.cnt || cnt_down !== e.dn || ovf !== e.ov || wave_a !== e.a || wave_b !== e.b) begin
        fails++;
        $display("FAIL %s: got cnt=%0d dn=%b ovf=%b a=%b b=%b expected cnt=%0d dn=%b ovf=%b a=%b b=%b",
                 e.tag, count, cnt_down, ovf, wave_a, wave_b, e.cnt, e.dn, e.ov, e.a, e.b);
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1
    do_reset();
    // R2 R4: free-run, toggle on A, drive-high on B
    c_kind = 0; c_cmpa = 10; c_codea = 1; c_cmpb = 200; c_codeb = 3;
    run(600, "R2_R4 free-run");
    // R5: strobes in free-run, with and without ticks
    c_codea = 1; c_codeb = 2; frc_en = 1; tick_pat = 1;
    run(150, "R5 strobe free-run");
    tick_pat = 2;
    run(40, "R5 strobe no tick");
    frc_en = 0; tick_pat = 0;
    // R3 R4: clear on compare
    do_reset();
    c_kind = 1; c_cmpa = 20; c_codea = 1; c_cmpb = 5; c_codeb = 3;
    run(60, "R3_R4 clear-on-compare");
    c_codeb = 2;
    run(60, "R3_R4 clear-on-compare low");
    // R6 R7: fast fixed TOP, B compare equal to TOP (wrap wins)
    do_reset();
    c_kind = 2; c_top = 0; c_cmpa = 64; c_codea = 2; c_cmpb = 255; c_codeb = 3;
    run(600, "R6_R7 fast fixed");
    // R5: strobes ignored in PWM
    frc_en = 1;
    run(100, "R5 strobe ignored fast");
    frc_en = 0;
    // R10: code 1 holds A when TOP fixed, and holds B
    c_codea = 1; c_codeb = 1;
    run(300, "R10 code1 fixed top");
    // R10 R7: TOP from A, A toggles, B compare 0
    do_reset();
    c_kind = 2; c_top = 1; c_cmpa = 49; c_codea = 1; c_cmpb = 0; c_codeb = 2;
    run(175, "R10_R7 fast reg top");
    c_codea = 2;
    run(120, "R10 A holds under code 2");
    // R11: code change acts only at next event
    c_codeb = 3;
    run(120, "R11 code change");
    // R12: sparse ticks
    tick_pat = 1;
    run(300, "R12 sparse tick");
    tick_pat = 2;
    run(30, "R12 no tick");
    tick_pat = 0;
    // R8 R9: phase fixed TOP
    do_reset();
    c_kind = 3; c_top = 0; c_cmpa = 100; c_codea = 2; c_cmpb = 0; c_codeb = 3;
    run(1100, "R8_R9 phase fixed");
    // R9 R10: phase with TOP from A, B compare equal to TOP
    do_reset();
    c_kind = 3; c_top = 1; c_cmpa = 30; c_codea = 1; c_cmpb = 30; c_codeb = 2;
    run(250, "R9_R10 phase reg top");
    frc_en = 1;
    run(80, "R5 strobe ignored phase");
    frc_en = 0;
    // R8: leaving phase clears the direction
    c_kind = 0;
    run(20, "R8 leave phase");
    @(posedge clk); #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule